// File: doc/BRIEF.md
# Thermal current foldback controller

This block turns a digital junction-temperature reading into a current-scale command for an LED current regulator. While the die is cool, the command is full scale. Above an activation temperature the command falls steeply, then more gently, and it reaches zero at a trip point. At the trip point the block latches a shutdown. That shutdown clears only after the die has cooled by a fixed hysteresis. The die may bounce between shutdown and normal operation many times, and each round trip behaves the same way.

Readings arrive as signed whole degrees Celsius, qualified by a strobe. The scale command is given in units of 0.01 %, so full scale is 10000. A driver-enable request gates the command. The shutdown state keeps tracking temperature even while the driver is not requested, so re-enabling a hot driver does not bypass the thermal latch.

Top module: `thermal_foldback`

## Requirements
- R1: During and directly after reset, `scale_o` is 0 and `drive_active_o` and `shutdown_o` are both 0.
- R2: Until the first reading is accepted, `scale_o` stays 0 and `drive_active_o` stays 0, whatever the value of `drive_req_i`.
- R3: A reading is accepted at a rising edge where `temp_valid_i` is 1. All three outputs reflect that reading after the next rising edge. When `temp_valid_i` is 0, `temp_i` has no effect on the outputs.
- R4: For readings below 130, including negative ones, an enabled driver gets `scale_o` = 10000.
- R5: For readings from 130 through 155, the scale follows the steep line 10000 - 325*(T-130). For example, 131 gives 9675, 150 gives 3500 and 153 gives 2525.
- R6: For readings of 130 and above, the scale is the larger of the steep line and the shallow line 125*(170-T), and it is never negative. Examples: 156 gives 1750, 160 gives 1250 and 169 gives 125. The result never exceeds 10000 and never rises as the temperature rises.
- R7: A reading of 170 or more sets `shutdown_o` to 1 and forces `scale_o` to 0 and `drive_active_o` to 0.
- R8: Once set, `shutdown_o` stays 1 for every reading of 155 or more, with the scale held at 0. The first reading of 154 or less clears it, and the normal curve applies again from that reading.
- R9: With `drive_req_i` at 0, `scale_o` and `drive_active_o` are 0 one edge later. The shutdown flag still sets and clears from readings as in R7 and R8.
- R10: `drive_active_o` is 1 exactly when the driver is requested, a reading has been accepted and there is no shutdown. While it is 1, `scale_o` is nonzero.
- R11: Repeated trips to shutdown and recoveries behave the same on every cycle, with no lasting state left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| temp_valid_i | input | 1 | Qualifies `temp_i` for one cycle |
| temp_i | input | TEMP_W | Signed junction temperature, whole degrees C |
| drive_req_i | input | 1 | Driver enable request, active high |
| scale_o | output | SCALE_W | Current scale in 0.01 % units (10000 = full) |
| drive_active_o | output | 1 | Driver is permitted to conduct |
| shutdown_o | output | 1 | Thermal shutdown latched |

## Verification
The hardest states to reach from the ports are the hysteresis band of 155 to 169 with the latch already set, and a latch that was set while the driver was not requested. Neither can be seen from a single reading, because both depend on the order of earlier readings. The stimulus therefore first trips the latch with a reading of 170 or more. It then walks back down through 160, 155 and 154. It repeats this walk with the request low, then raises the request inside the band to confirm the latch still holds the scale at zero. A monotonic sweep and a series of repeated trip-and-recover loops cover the curve continuity and the absence of any state that persists after recovery.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

  // Piecewise derating: full below knee, zero at/after off point,
  // otherwise the larger of the steep line and the shallow line.
  function automatic int fold_curve(input int t, input int knee, input int off,
                                    input int steep, input int shallow, input int full);
    int s;
    int h;
    int r;
    if (t < knee) return full;
    if (t >= off) return 0;
    s = full - steep * (t - knee);
    h = shallow * (off - t);
    r = (s > h) ? s : h;
    if (r < 0) r = 0;
    return r;
  endfunction

  // Hysteretic trip latch: set at or above off, release below clr.
  function automatic logic next_trip(input logic cur, input int t, input int off, input int clr);
    if (cur) return (t >= clr);
    return (t >= off);
  endfunction

endpackage

// File: rtl/tfb_sample.sv
module tfb_sample #(
  parameter int TEMP_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  output logic signed [TEMP_W-1:0] temp_o,
  output logic                     primed_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      temp_o   <= '0;
      primed_o <= 1'b0;
    end else if (valid_i) begin
      temp_o   <= temp_i;
      primed_o <= 1'b1;
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(temp_o));

  // R2
  primed_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_o |=> primed_o);

endmodule

// File: rtl/tfb_hyst.sv
module tfb_hyst #(
  parameter int TEMP_W = 10,
  parameter int T_OFF  = 170,
  parameter int T_CLR  = 155
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [TEMP_W-1:0] temp_i,
  output logic                     trip_next_o,
  output logic                     trip_o
);
  import tfb_pkg::*;

  always_comb trip_next_o = next_trip(trip_o, int'(temp_i), T_OFF, T_CLR);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) trip_o <= 1'b0;
    else         trip_o <= trip_next_o;
  end

  // R7
  trip_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> (int'($past(temp_i)) >= T_OFF));

  // R8
  trip_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trip_o) |-> (int'($past(temp_i)) < T_CLR));

  // R8
  trip_band_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && int'(temp_i) >= T_CLR) |=> trip_o);

endmodule

// File: rtl/tfb_curve.sv
module tfb_curve #(
  parameter int TEMP_W  = 10,
  parameter int SCALE_W = 14,
  parameter int T_KNEE  = 130,
  parameter int T_OFF   = 170,
  parameter int STEEP   = 325,
  parameter int SHALLOW = 125,
  parameter int FULL    = 10000
) (
  input  logic signed [TEMP_W-1:0] temp_i,
  output logic [SCALE_W-1:0]       scale_o
);
  import tfb_pkg::*;

  always_comb scale_o = SCALE_W'(fold_curve(int'(temp_i), T_KNEE, T_OFF, STEEP, SHALLOW, FULL));

endmodule

// File: rtl/thermal_foldback.sv
module thermal_foldback #(
  parameter int TEMP_W    = 10,
  parameter int SCALE_W   = 14,
  parameter int T_KNEE    = 130,
  parameter int T_LOW     = 150,
  parameter int T_OFF     = 170,
  parameter int T_HYST    = 15,
  parameter int STEEP     = 325,
  parameter int FULL      = 10000,
  parameter int FLOOR_LVL = 2500
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     temp_valid_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     drive_req_i,
  output logic [SCALE_W-1:0]       scale_o,
  output logic                     drive_active_o,
  output logic                     shutdown_o
);
  localparam int SHALLOW = FLOOR_LVL / (T_OFF - T_LOW);
  localparam int T_CLR   = T_OFF - T_HYST;

  logic signed [TEMP_W-1:0] temp_r;
  logic                     primed;
  logic                     trip_next;
  logic [SCALE_W-1:0]       curve_val;
  logic                     allow;
  logic [SCALE_W-1:0]       scale_q;
  logic                     active_q;

  tfb_sample #(.TEMP_W(TEMP_W)) sample_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(temp_valid_i), .temp_i(temp_i),
    .temp_o(temp_r), .primed_o(primed)
  );

  tfb_hyst #(.TEMP_W(TEMP_W), .T_OFF(T_OFF), .T_CLR(T_CLR)) hyst_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_r),
    .trip_next_o(trip_next), .trip_o(shutdown_o)
  );

  tfb_curve #(.TEMP_W(TEMP_W), .SCALE_W(SCALE_W), .T_KNEE(T_KNEE), .T_OFF(T_OFF),
              .STEEP(STEEP), .SHALLOW(SHALLOW), .FULL(FULL)) curve_i (
    .temp_i(temp_r), .scale_o(curve_val)
  );

  always_comb allow = drive_req_i && primed && !trip_next;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      scale_q  <= '0;
      active_q <= 1'b0;
    end else begin
      scale_q  <= allow ? curve_val : '0;
      active_q <= allow;
    end
  end

  assign scale_o        = scale_q;
  assign drive_active_o = active_q;

  // R6
  scale_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(scale_q) <= FULL);

  // R7
  trip_blocks_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> (scale_q == '0 && !active_q));

  // R9
  req_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_req_i |=> (scale_q == '0 && !active_q));

  // R10
  active_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (scale_q != '0));

endmodule

// File: tb/thermal_foldback_tb_top.sv
module thermal_foldback_tb_top;
  localparam int TEMP_W  = 10;
  localparam int SCALE_W = 14;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     valid = 1'b0;
  logic signed [TEMP_W-1:0] temp = '0;
  logic                     req = 1'b0;
  logic [SCALE_W-1:0]       scale;
  logic                     active;
  logic                     shut;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;
  bit  m_shut = 0;

  always #4 clk = ~clk;

  thermal_foldback dut_i (
    .clk_i(clk), .rst_ni(rst_n), .temp_valid_i(valid), .temp_i(temp),
    .drive_req_i(req), .scale_o(scale), .drive_active_o(active), .shutdown_o(shut)
  );

  // Region-by-region restatement of the derating curve
  function automatic int exp_curve(input int t);
    if (t < 130)  return 10000;
    if (t <= 155) return 10000 - 325 * (t - 130);
    if (t < 170)  return 125 * (170 - t);
    return 0;
  endfunction

  task automatic check(input string req_tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  // Present one reading, then sample after the output edge
  task automatic apply(input int t);
    @(negedge clk);
    temp  = TEMP_W'(t);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    if (m_shut) m_shut = (t >= 155);
    else        m_shut = (t >= 170);
  endtask

  task automatic check_all(input string tag, input int t);
    int e;
    e = (req && !m_shut) ? exp_curve(t) : 0;
    check({tag, " scale"}, int'(scale), e);
    check({tag, " active"}, int'(active), (req && !m_shut) ? 1 : 0);
    check({tag, " shutdown"}, int'(shut), m_shut ? 1 : 0);
  endtask

  task automatic t_reset();
    check("R1 scale", int'(scale), 0);
    check("R1 active", int'(active), 0);
    check("R1 shutdown", int'(shut), 0);
  endtask

  task automatic t_unprimed();
    @(negedge clk); req = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 scale", int'(scale), 0);
    check("R2 active", int'(active), 0);
  endtask

  task automatic t_cool();
    int temps[3] = '{25, -40, 129};
    foreach (temps[i]) begin
      apply(temps[i]);
      check_all("R4", temps[i]);
    end
  endtask

  task automatic t_steep();
    int temps[5] = '{130, 131, 140, 150, 153};
    foreach (temps[i]) begin
      apply(temps[i]);
      check_all("R5", temps[i]);
    end
    apply(131);
    check("R5 131", int'(scale), 9675);
    apply(153);
    check("R5 153", int'(scale), 2525);
  endtask

  task automatic t_shallow();
    apply(156); check("R6 156", int'(scale), 1750);
    apply(160); check("R6 160", int'(scale), 1250);
    apply(169); check("R6 169", int'(scale), 125);
    check("R10 active at 169", int'(active), 1);
  endtask

  task automatic t_sweep();
    int prev = 10000;
    for (int t = 100; t < 170; t++) begin
      apply(t);
      check_all("R6 sweep", t);
      if (int'(scale) > prev) check("R6 monotonic", int'(scale), prev);
      prev = int'(scale);
    end
  endtask

  task automatic t_latency();
    @(negedge clk);
    temp = TEMP_W'(140); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R3 not yet", int'(scale), 125);
    @(negedge clk);
    if (m_shut) m_shut = 0;
    check("R3 one edge later", int'(scale), 6750);
    @(negedge clk); temp = TEMP_W'(20);
    repeat (3) @(negedge clk);
    check("R3 idle strobe", int'(scale), 6750);
  endtask

  task automatic t_trip();
    apply(170); check_all("R7 at 170", 170);
    check("R7 shutdown", int'(shut), 1);
    apply(200); check_all("R7 at 200", 200);
    apply(160); check_all("R8 band 160", 160);
    check("R8 scale held", int'(scale), 0);
    apply(155); check_all("R8 band 155", 155);
    check("R8 still latched", int'(shut), 1);
    apply(154); check_all("R8 release", 154);
    check("R8 after release", int'(scale), 2200);
  endtask

  task automatic t_disabled();
    apply(120);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    check("R9 scale", int'(scale), 0);
    check("R9 active", int'(active), 0);
    apply(172); check_all("R9 tracked trip", 172);
    apply(160); check_all("R9 band", 160);
    @(negedge clk); req = 1'b1;
    @(negedge clk);
    check("R9 latch survives enable", int'(scale), 0);
    check("R10 active while latched", int'(active), 0);
    apply(154); check_all("R9 recover", 154);
    check("R10 active", int'(active), 1);
  endtask

  task automatic t_cycles();
    for (int k = 0; k < 4; k++) begin
      apply(175); check_all("R11 trip", 175);
      apply(158); check_all("R11 band", 158);
      apply(100); check_all("R11 recover", 100);
      check("R11 full", int'(scale), 10000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unprimed();
    t_cool();
    t_steep();
    t_shallow();
    t_sweep();
    t_latency();
    t_trip();
    t_disabled();
    t_cycles();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule